// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges five reset causes into one stretched system reset and keeps a byte-wide status register that names the cause of the most recent reset. The causes are an active-low external reset pin, a detector for a stalled monitored clock, an armed comparator supply monitor, a watchdog timeout pulse and an illegal program-memory access. The illegal-access check runs inside the block, on the requests and addresses of the flash port.

All logic runs on a free-running reference clock. The pin, the comparator output and the monitored clock are asynchronous and pass through two-flop synchronizers. The stall detector counts reference cycles between edges of the monitored clock. Its limit is derived from the reference frequency so that it equals 100 µs. A power-on input resets the block asynchronously. Every other cause asserts the reset at the next reference edge and releases it synchronously after a minimum hold time.

Software reads the cause flags through the register port. Two of the flag bits also work as write-to-enable controls: one for the stall detector and one for the comparator. The watchdog counter, the comparator and the flash array are not part of this block. They appear only as input signals.

Top module: `rstctl_top`

## Requirements
- R1: After `por_n` is released, `sys_rst_n` stays low for STRETCH (default 8) reference edges and then goes high. `reg_rdata` then reads 0x00.
- R2: When `ext_rst_n` is low, `sys_rst_n` goes low at the third reference edge, counting the two synchronizer flops. It stays low while the pin is low. It is released STRETCH edges after the synchronized pin returns high. The status then reads 0x01 (bit 0).
- R3: Writing 1 to status bit 2 enables the stall detector. If `mon_clk` then shows no edge for REF_KHZ/10 reference cycles (default 64), a reset fires and the status reads 0x04. No reset fires while `mon_clk` toggles, or while the detector is disabled.
- R4: Writing 1 to status bit 5 arms the comparator. When armed, a low synchronized `cmp_out` fires a reset and the status reads 0x20. When unarmed, a low `cmp_out` has no effect.
- R5: A one-cycle `wdt_timeout` pulse fires a reset at the next edge, and the status reads 0x08 (bit 3).
- R6: A flash error fires a reset and the status reads 0x40 (bit 6). The access kind in `fl_kind` is coded 00 fetch, 01 data read, 10 write/erase and 11 none. An error is any request, of kind fetch, read, or write with `fl_wr_en`=1, that either has an address above CODE_TOP (default 0x1DFF) or arrives while `fl_lock`=1. A write with `fl_wr_en`=0 is never an error.
- R7: When causes coincide at one edge, only the highest one is recorded. The priority, highest first, is pin, stall, comparator, watchdog, flash.
- R8: Each reset clears all earlier flags, so exactly one flag is set after any cause-triggered reset.
- R9: A single-cycle internal cause holds `sys_rst_n` low for exactly STRETCH edges, counting from the edge that sampled it.
- R10: Any reset clears both enables. Register writes made while `sys_rst_n` is low are ignored. Writes change only the two enables and never the flags that `reg_rdata` shows.
- R11: After any reset, `wdt_en` reads 1 and `wdt_div` reads 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock for all logic |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | Raw external reset pin, active low |
| mon_clk | input | 1 | Monitored system clock, sampled as data |
| cmp_out | input | 1 | Supply comparator output, low means undervoltage |
| wdt_timeout | input | 1 | Watchdog timeout pulse |
| fl_req | input | 1 | Flash access request valid |
| fl_kind | input | 2 | Access kind: 00 fetch, 01 read, 10 write/erase, 11 none |
| fl_addr | input | AW | Flash access address |
| fl_wr_en | input | 1 | Program-store write enable |
| fl_lock | input | 1 | Security lock blocks this access |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 8 | Write data (bit 2 stall enable, bit 5 comparator arm) |
| reg_rdata | output | 8 | Cause flags |
| sys_rst_n | output | 1 | Stretched system reset, active low |
| wdt_en | output | 1 | Watchdog enabled after reset |
| wdt_div | output | DIVW | Watchdog clock divide ratio |

## Verification
The hardest condition to reach from the ports is several causes arriving at the same reference edge. Causes on the pin and the comparator pass through synchronizers, while the watchdog and flash causes are sampled on the edge itself. The stimulus therefore drives the pin and the comparator first and adds the watchdog pulse and an illegal fetch two cycles later, so that all of them meet at the same edge. The stalled-clock case is reached by running a toggler on `mon_clk` and then stopping it. Random flash traffic is weighted toward the 0x1DFF boundary, together with random watchdog pulses.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

  typedef enum logic [1:0] {
    FL_FETCH = 2'b00,
    FL_READ  = 2'b01,
    FL_WRITE = 2'b10,
    FL_IDLE  = 2'b11
  } fl_kind_e;

  localparam int ST_W    = 8;
  localparam int ST_PIN  = 0;
  localparam int ST_MCD  = 2;
  localparam int ST_WDT  = 3;
  localparam int ST_CMP  = 5;
  localparam int ST_FERR = 6;

  // Field order follows priority, highest first.
  typedef struct packed {
    logic pin;
    logic mcd;
    logic cmp;
    logic wdt;
    logic ferr;
  } cause_t;

endpackage

// File: rtl/rstctl_sync.sv
module rstctl_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q;
    logic out_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[i];
        out_q  <= RST_VAL[i];
      end else begin
        meta_q <= d[i];
        out_q  <= meta_q;
      end
    end
    assign q[i] = out_q;
  end

endmodule

// File: rtl/rstctl_mcd.sv
module rstctl_mcd #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic mon,
  output logic timeout
);

  localparam int CW = $clog2(LIMIT + 1);

  logic          mon_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          mon_edge;

  assign mon_edge = mon ^ mon_q;

  always_comb begin
    cnt_d = cnt_q;
    if (!en || mon_edge) cnt_d = '0;
    else if (cnt_q != CW'(LIMIT)) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mon_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      mon_q <= mon;
      cnt_q <= cnt_d;
    end
  end

  assign timeout = en && (cnt_q == CW'(LIMIT));

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LIMIT));

  // R3
  edge_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mon_edge |=> !timeout);

endmodule

// File: rtl/rstctl_flchk.sv
module rstctl_flchk
  import rstctl_pkg::*;
#(
  parameter int           AW       = 16,
  parameter logic [AW-1:0] CODE_TOP = 16'h1DFF
) (
  input  logic          req,
  input  logic [1:0]    kind,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          lock,
  output logic          err
);

  fl_kind_e kind_e;
  logic     is_flash;
  logic     out_of_range;

  always_comb begin
    kind_e = fl_kind_e'(kind);
    unique case (kind_e)
      FL_FETCH, FL_READ: is_flash = 1'b1;
      FL_WRITE:          is_flash = wr_en;
      default:           is_flash = 1'b0;
    endcase
    out_of_range = addr > CODE_TOP;
    err          = req && is_flash && (lock || out_of_range);
  end

endmodule

// File: rtl/rstctl_stretch.sv
module rstctl_stretch #(
  parameter int STRETCH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);

  localparam int CW = $clog2(STRETCH + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  always_comb begin
    if (load) cnt_d = CW'(STRETCH);
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    else cnt_d = cnt_q;
    busy_d = (cnt_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CW'(STRETCH);
      busy_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;

  // R9
  load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy_q);

endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
  import rstctl_pkg::*;
#(
  parameter int           AW       = 16,
  parameter logic [AW-1:0] CODE_TOP = 16'h1DFF,
  parameter int           REF_KHZ  = 640,
  parameter int           STRETCH  = 8,
  parameter int           WDT_DIV  = 12,
  parameter int           DIVW     = 4
) (
  input  logic            ref_clk,
  input  logic            por_n,
  input  logic            ext_rst_n,
  input  logic            mon_clk,
  input  logic            cmp_out,
  input  logic            wdt_timeout,
  input  logic            fl_req,
  input  logic [1:0]      fl_kind,
  input  logic [AW-1:0]   fl_addr,
  input  logic            fl_wr_en,
  input  logic            fl_lock,
  input  logic            reg_wr,
  input  logic [ST_W-1:0] reg_wdata,
  output logic [ST_W-1:0] reg_rdata,
  output logic            sys_rst_n,
  output logic            wdt_en,
  output logic [DIVW-1:0] wdt_div
);

  // 100 us expressed in reference cycles
  localparam int MCD_LIMIT = (REF_KHZ / 10 < 1) ? 1 : REF_KHZ / 10;

  logic            pin_s, cmp_s, mon_s;
  logic            mcd_to, fl_err;
  logic            rst_q;
  logic            fire, load;
  cause_t          raw;
  logic [ST_W-1:0] flag_q, flag_d;
  logic            mcd_en_q, mcd_en_d;
  logic            cmp_arm_q, cmp_arm_d;
  logic            unused_wbits;

  rstctl_sync #(.W(3), .RST_VAL(3'b110)) u_sync (
    .clk   (ref_clk),
    .rst_n (por_n),
    .d     ({ext_rst_n, cmp_out, mon_clk}),
    .q     ({pin_s, cmp_s, mon_s})
  );

  rstctl_mcd #(.LIMIT(MCD_LIMIT)) u_mcd (
    .clk     (ref_clk),
    .rst_n   (por_n),
    .en      (mcd_en_q && !rst_q),
    .mon     (mon_s),
    .timeout (mcd_to)
  );

  rstctl_flchk #(.AW(AW), .CODE_TOP(CODE_TOP)) u_flchk (
    .req   (fl_req),
    .kind  (fl_kind),
    .addr  (fl_addr),
    .wr_en (fl_wr_en),
    .lock  (fl_lock),
    .err   (fl_err)
  );

  rstctl_stretch #(.STRETCH(STRETCH)) u_stretch (
    .clk   (ref_clk),
    .rst_n (por_n),
    .load  (load),
    .busy  (rst_q)
  );

  always_comb begin
    raw.pin  = !pin_s;
    raw.mcd  = mcd_to;
    raw.cmp  = cmp_arm_q && !cmp_s;
    raw.wdt  = wdt_timeout;
    raw.ferr = fl_err;
  end

  assign fire = !rst_q && (raw != '0);
  // a held pin keeps reloading the stretch counter
  assign load = fire || raw.pin;

  always_comb begin
    flag_d    = flag_q;
    mcd_en_d  = mcd_en_q;
    cmp_arm_d = cmp_arm_q;
    if (fire) begin
      flag_d    = '0;
      mcd_en_d  = 1'b0;
      cmp_arm_d = 1'b0;
      if (raw.pin)      flag_d[ST_PIN]  = 1'b1;
      else if (raw.mcd) flag_d[ST_MCD]  = 1'b1;
      else if (raw.cmp) flag_d[ST_CMP]  = 1'b1;
      else if (raw.wdt) flag_d[ST_WDT]  = 1'b1;
      else              flag_d[ST_FERR] = 1'b1;
    end else if (reg_wr && !rst_q) begin
      mcd_en_d  = reg_wdata[ST_MCD];
      cmp_arm_d = reg_wdata[ST_CMP];
    end
  end

  always_ff @(posedge ref_clk or negedge por_n) begin
    if (!por_n) begin
      flag_q    <= '0;
      mcd_en_q  <= 1'b0;
      cmp_arm_q <= 1'b0;
    end else begin
      flag_q    <= flag_d;
      mcd_en_q  <= mcd_en_d;
      cmp_arm_q <= cmp_arm_d;
    end
  end

  assign unused_wbits = ^{reg_wdata[7:6], reg_wdata[4:3], reg_wdata[1:0]};

  assign reg_rdata = flag_q;
  assign sys_rst_n = !rst_q;
  assign wdt_en    = 1'b1;
  assign wdt_div   = DIVW'(WDT_DIV);

  // R8
  flags_onehot_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
    $onehot0(flag_q));

  // R9
  fire_rst_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
    fire |=> !sys_rst_n);

  // R2
  pin_hold_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
    raw.pin |=> !sys_rst_n);

  // R7
  pin_prio_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
    (fire && raw.pin) |=> (reg_rdata == 8'h01));

  // R10
  wr_in_rst_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
    (rst_q && reg_wr) |=> ($stable(mcd_en_q) && $stable(cmp_arm_q)));

  // R6
  fetch_err_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
    (fl_req && fl_kind == 2'b00 && fl_addr > CODE_TOP) |=> !sys_rst_n);

endmodule

// File: tb/sim_rstctl_top.sv
module sim_rstctl_top;

  localparam int CLK_PERIOD = 10;
  localparam int STRETCH    = 8;
  localparam int LIMIT      = 64;

  logic        clk = 1'b0;
  logic        por_n, ext_rst_n, mon_clk, cmp_out, wdt_timeout;
  logic        fl_req, fl_wr_en, fl_lock, reg_wr;
  logic [1:0]  fl_kind;
  logic [15:0] fl_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic        sys_rst_n, wdt_en;
  logic [3:0]  wdt_div;

  int checks = 0;
  int fails  = 0;
  bit mon_run = 1'b0;
  int mon_div = 0;
  logic [7:0] prev_st;

  rstctl_top u0 (
    .ref_clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .mon_clk(mon_clk),
    .cmp_out(cmp_out), .wdt_timeout(wdt_timeout), .fl_req(fl_req),
    .fl_kind(fl_kind), .fl_addr(fl_addr), .fl_wr_en(fl_wr_en),
    .fl_lock(fl_lock), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sys_rst_n(sys_rst_n), .wdt_en(wdt_en),
    .wdt_div(wdt_div)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (mon_run) begin
      mon_div++;
      if (mon_div >= 3) begin
        mon_clk = ~mon_clk;
        mon_div = 0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit flash_err(bit req, logic [1:0] kind, logic [15:0] addr,
                                   bit wren, bit lock);
    bit acc;
    acc = (kind == 2'b00) || (kind == 2'b01) || (kind == 2'b10 && wren);
    return req && acc && (lock || addr > 16'h1DFF);
  endfunction

  function automatic logic [7:0] exp_status(bit pin, bit mcd, bit cmp, bit wdt, bit fe);
    if (pin) return 8'h01;
    if (mcd) return 8'h04;
    if (cmp) return 8'h20;
    if (wdt) return 8'h08;
    if (fe)  return 8'h40;
    return 8'h00;
  endfunction

  task automatic clear_fl();
    fl_req = 0; fl_kind = 2'b11; fl_addr = '0; fl_wr_en = 0; fl_lock = 0;
  endtask

  task automatic wait_release(output int n);
    n = 0;
    while (!sys_rst_n && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic reg_write(input logic [7:0] d);
    reg_wr = 1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One cycle of watchdog and flash stimulus, then the expected outcome.
  task automatic trial(input bit wdt, input bit req, input logic [1:0] kind,
                       input logic [15:0] addr, input bit wren, input bit lock,
                       input string tag);
    bit fe, f;
    logic [7:0] e;
    int n;
    fe = flash_err(req, kind, addr, wren, lock);
    f  = wdt || fe;
    e  = f ? exp_status(0, 0, 0, wdt, fe) : prev_st;
    wdt_timeout = wdt; fl_req = req; fl_kind = kind; fl_addr = addr;
    fl_wr_en = wren; fl_lock = lock;
    @(negedge clk);
    wdt_timeout = 0; clear_fl();
    chk({tag, " rst"}, sys_rst_n, !f);
    chk({tag, " status"}, reg_rdata, e);
    prev_st = e;
    if (f) begin
      wait_release(n);
      chk("R9 stretch", n, STRETCH);
    end
    idle(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    por_n = 0; ext_rst_n = 1; mon_clk = 0; cmp_out = 1; wdt_timeout = 0;
    reg_wr = 0; reg_wdata = '0; clear_fl();
    prev_st = 8'h00;
    idle(3);
    chk("R1 rst during por", sys_rst_n, 0);
    por_n = 1;
    wait_release(n);
    chk("R1 por stretch", n, STRETCH);
    chk("R1 status", reg_rdata, 8'h00);
    chk("R11 wdt_en", wdt_en, 1);
    chk("R11 wdt_div", wdt_div, 12);
    mon_run = 1;

    // R4 unarmed comparator has no effect
    cmp_out = 0; idle(6);
    chk("R4 unarmed", sys_rst_n, 1);
    cmp_out = 1; idle(3);

    // R5 watchdog
    trial(1, 0, 2'b11, 16'h0, 0, 0, "R5 wdt");

    // R10 writes ignored during reset, enables cleared by reset
    reg_write(8'h24);
    wdt_timeout = 1; @(negedge clk); wdt_timeout = 0;
    chk("R5 wdt again", sys_rst_n, 0);
    reg_write(8'h24);
    wait_release(n);
    cmp_out = 0; idle(6);
    chk("R10 write in reset ignored", sys_rst_n, 1);
    cmp_out = 1;
    reg_write(8'hDB);
    chk("R10 flags unaffected by write", reg_rdata, 8'h08);

    // R4 armed comparator
    reg_write(8'h20);
    cmp_out = 0; idle(3);
    chk("R4 armed rst", sys_rst_n, 0);
    chk("R4 status", reg_rdata, 8'h20);
    wait_release(n);
    chk("R9 cmp stretch", n, STRETCH);
    idle(5);
    chk("R10 arm cleared by reset", sys_rst_n, 1);
    cmp_out = 1; idle(3);

    // R3 stall detector
    reg_write(8'h04);
    idle(3 * LIMIT);
    chk("R3 toggling no reset", sys_rst_n, 1);
    mon_run = 0;
    n = 0;
    while (sys_rst_n && n < LIMIT + 20) begin @(negedge clk); n++; end
    chk("R3 stall rst", sys_rst_n, 0);
    chk("R3 timeout window", (n >= LIMIT - 4) && (n <= LIMIT + 6), 1);
    chk("R3 status", reg_rdata, 8'h04);
    wait_release(n);
    idle(2 * LIMIT);
    chk("R3 disabled no reset", sys_rst_n, 1);
    mon_run = 1;

    // R2 pin reset
    ext_rst_n = 0; idle(2);
    chk("R2 not yet", sys_rst_n, 1);
    idle(1);
    chk("R2 rst", sys_rst_n, 0);
    chk("R2 status", reg_rdata, 8'h01);
    idle(20);
    chk("R2 held", sys_rst_n, 0);
    ext_rst_n = 1;
    wait_release(n);
    chk("R2 release", n, STRETCH + 2);

    // R7 coincident causes, pin wins
    reg_write(8'h24);
    ext_rst_n = 0; cmp_out = 0; idle(2);
    wdt_timeout = 1; fl_req = 1; fl_kind = 2'b00; fl_addr = 16'hFFFF;
    @(negedge clk);
    wdt_timeout = 0; clear_fl();
    chk("R7 pin first rst", sys_rst_n, 0);
    chk("R7 pin first", reg_rdata, 8'h01);
    ext_rst_n = 1; cmp_out = 1;
    wait_release(n);
    // R7 comparator beats watchdog and flash
    reg_write(8'h20);
    cmp_out = 0; idle(2);
    wdt_timeout = 1; fl_req = 1; fl_kind = 2'b01; fl_addr = 16'h1E00;
    @(negedge clk);
    wdt_timeout = 0; clear_fl();
    chk("R7 cmp over wdt", reg_rdata, 8'h20);
    chk("R8 single flag", $countones(reg_rdata), 1);
    cmp_out = 1;
    wait_release(n);
    prev_st = 8'h20;

    // R6 directed flash corners
    trial(0, 1, 2'b01, 16'h1DFF, 0, 0, "R6 read at top");
    trial(0, 1, 2'b01, 16'h1E00, 0, 0, "R6 read above");
    trial(0, 1, 2'b10, 16'h1E00, 0, 0, "R6 plain write");
    trial(0, 1, 2'b10, 16'h1E00, 1, 0, "R6 flash write");
    trial(0, 1, 2'b00, 16'h0000, 0, 1, "R6 locked fetch");
    trial(0, 1, 2'b11, 16'hFFFF, 1, 1, "R6 no access");
    trial(1, 1, 2'b00, 16'hF000, 0, 0, "R7 wdt over flash");

    // Random watchdog and flash traffic around the boundary
    for (int i = 0; i < 60; i++) begin
      logic [15:0] a;
      if ($urandom % 2) a = 16'h1DFF + 16'($urandom % 5) - 16'd2;
      else a = 16'($urandom);
      trial(($urandom % 4) == 0, ($urandom % 4) != 0, 2'($urandom), a,
            1'($urandom), ($urandom % 6) == 0, "R6 random");
    end
    chk("R11 wdt_en after resets", wdt_en, 1);
    chk("R11 wdt_div after resets", wdt_div, 12);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule